// File: doc/BRIEF.md
# Receive-Only Byte Request Sequencer

This block runs receive-only serial transfers on a four-wire serial link where the chip is the clock master. Software writes a byte count into the request input. The sequencer then toggles the serial clock for exactly eight bits per requested byte and holds the outgoing data line at a fixed idle level. It assembles the incoming bytes into 32-bit words and hands each word to a receive FIFO through a one-cycle push strobe.

A down-counter reports how many bytes are still to come. When the request is not a multiple of four bytes, the last word is short. It is pushed with a valid-byte count of 1 to 3, and the earliest of its bytes sits in the highest valid byte lane. A one-cycle done strobe marks the final push.

The sequencer ignores a request that arrives while a transfer is still in flight and raises an error flag. The FIFO storage and any bus decoding sit outside this block.

Top module: `rx_byte_seq`

## Requirements
- R1: A request with a nonzero count N written while idle makes `busy` high and `remaining` equal to N in the cycle after the write.
- R2: A transfer of N bytes produces exactly 8*N rising edges on `sclk`. `sclk` is low whenever `busy` is low, and `mosi` stays at the idle level 1 throughout.
- R3: Bits are sampled on the rising edge of `sclk`, most significant bit of each byte first. Each `sclk` half period lasts SCLK_HALF clock cycles.
- R4: `remaining` drops by exactly one as each byte completes and never rises during a transfer.
- R5: Every group of four consecutive bytes is pushed as one 32-bit word with `valid_bytes` = 4. The first byte of the group is in bits [31:24] and the last in bits [7:0].
- R6: If N mod 4 = r is nonzero, the final push has `valid_bytes` = r. Its bytes occupy the low r byte lanes, the earliest of them in lane r-1 (lane k is bits [8k+7:8k]), and the unused upper lanes are zero. A short word is only ever pushed as the final word.
- R7: `done` pulses high for one cycle together with the final push, and `remaining` is 0 in that cycle. `busy` falls once the last `sclk` falling edge has been driven.
- R8: A request written while `busy` is high changes neither `remaining` nor the number of clock edges, and sets `req_err` in the next cycle. `req_err` is cleared by the next accepted request.
- R9: A request with count 0 written while idle starts nothing: `busy` stays low, no `sclk` edge occurs and `req_err` is unchanged.
- R10: After reset `busy`, `sclk`, `push_valid`, `done` and `req_err` are 0, and `remaining` and `valid_bytes` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | One-cycle write strobe for the request count |
| req_count | input | CNT_W | Number of bytes to receive |
| miso | input | 1 | Serial data from the target device |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Outgoing data line, held at the idle level |
| busy | output | 1 | High while a transfer is running |
| remaining | output | CNT_W | Bytes still to be received |
| req_err | output | 1 | Sticky flag for a request rejected while busy |
| push_valid | output | 1 | One-cycle strobe presenting a word to the FIFO |
| push_data | output | 32 | Packed receive word |
| valid_bytes | output | 3 | Valid byte count of the last pushed word (1..4) |
| done | output | 1 | One-cycle strobe on the final push of a transfer |

## Verification
Request lengths from 1 to 13 bytes are swept. This covers every residue modulo four, so full words alone, full words followed by a 1-, 2- or 3-byte tail, and a lone short word are each seen. The target model streams a byte sequence that depends on both the byte index and the length. A swapped lane, a reversed bit order or a stale byte therefore gives a different word from the one computed in the bench. A second request in the middle of a transfer, followed by a clean request and a zero-length request, separates the rejection path from the normal start path.

// File: rtl/rxs_pkg.sv
// Package: shared widths and types for the receive-only byte sequencer.
// Assumes a word holds four bytes; the packer relies on that.
package rxs_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int VB_W       = $clog2(WORD_BYTES + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [VB_W-1:0]   vbytes_t;
endpackage

// File: rtl/rxs_clkgen.sv
// Module: serial clock generator.
// Toggles sclk every HALF clock cycles while run is high and holds it low
// otherwise. It flags, combinationally, the cycle whose edge makes sclk rise
// or fall. Assumes HALF >= 1.
module rxs_clkgen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == LAST);
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the clock is parked low while the sequencer is stopped.
    assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);
endmodule

// File: rtl/rxs_shifter.sv
// Module: serial-to-byte shifter.
// Samples miso on each rising sclk tick, MSB first. It marks the tick that
// completes a byte and presents that byte in the same cycle. A start pulse
// realigns the bit counter.
module rxs_shifter
    import rxs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  rise_tick,
    input  logic  miso,
    output logic  byte_strb,
    output byte_t byte_out
);
    localparam int BC_W = $clog2(BYTE_W);

    logic [BYTE_W-2:0] shreg;
    logic [BC_W-1:0]   bitcnt;

    assign byte_strb = rise_tick && (bitcnt == BC_W'(BYTE_W - 1));
    assign byte_out  = {shreg, miso};

    // Shift in one bit per rising tick and count bit position.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else if (rise_tick) begin
            shreg  <= byte_out[BYTE_W-2:0];
            bitcnt <= bitcnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxs_packer.sv
// Module: byte-to-word packer.
// Appends each byte at the low end of an accumulator, so the earliest byte
// ends up in the highest filled lane. Pushes when four bytes are held or when
// the last byte of the request arrives. The valid-byte count is held until
// the next push.
module rxs_packer
    import rxs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    byte_strb,
    input  byte_t   byte_in,
    input  logic    last_byte,
    output logic    push_valid,
    output word_t   push_data,
    output vbytes_t valid_bytes
);
    localparam int FILL_W = $clog2(WORD_BYTES);

    word_t             acc;
    word_t             acc_next;
    logic [FILL_W-1:0] fill;
    vbytes_t           fill_next;
    logic              flush;

    assign acc_next  = {acc[WORD_W-BYTE_W-1:0], byte_in};
    assign fill_next = VB_W'(fill) + 1'b1;
    assign flush     = byte_strb && (last_byte || (fill_next == VB_W'(WORD_BYTES)));

    // Accumulate bytes and emit a word on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc         <= '0;
            fill        <= '0;
            push_valid  <= 1'b0;
            push_data   <= '0;
            valid_bytes <= '0;
        end else begin
            push_valid <= flush;
            if (start) begin
                acc  <= '0;
                fill <= '0;
            end else if (flush) begin
                push_data   <= acc_next;
                valid_bytes <= fill_next;
                acc         <= '0;
                fill        <= '0;
            end else if (byte_strb) begin
                acc  <= acc_next;
                fill <= fill_next[FILL_W-1:0];
            end
        end
    end

    // R6: a pushed word always carries between one and four valid bytes.
    assert_vbytes_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> (valid_bytes != '0) && (valid_bytes <= VB_W'(WORD_BYTES)));
endmodule

// File: rtl/rx_byte_seq.sv
// Module: receive-only byte request sequencer (top).
// Accepts a byte count while idle and drives sclk for 8 bits per byte with
// mosi held at IDLE_BIT. It counts the remaining bytes down and packs bytes
// into 32-bit pushes, the last one possibly short. A request seen while busy
// is dropped and flagged. Assumes the consumer accepts every push.
module rx_byte_seq
    import rxs_pkg::*;
#(
    parameter int   CNT_W      = 16,
    parameter int   SCLK_HALF  = 2,
    parameter logic IDLE_BIT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_wr,
    input  logic [CNT_W-1:0] req_count,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic [CNT_W-1:0] remaining,
    output logic             req_err,
    output logic             push_valid,
    output logic [31:0]      push_data,
    output logic [2:0]       valid_bytes,
    output logic             done
);
    logic    run;
    logic    start;
    logic    rise_tick;
    logic    fall_tick;
    logic    byte_strb;
    logic    last_byte;
    byte_t   rx_byte;
    word_t   word_q;
    vbytes_t vb_q;

    assign start     = req_wr && !run && (req_count != '0);
    assign last_byte = (remaining == CNT_W'(1));
    assign busy      = run;
    assign mosi      = IDLE_BIT;
    assign push_data = word_q;
    assign valid_bytes = 3'(vb_q);

    // Request acceptance, byte countdown, stop and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            remaining <= '0;
            req_err   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= byte_strb && last_byte;
            if (req_wr && run) begin
                req_err <= 1'b1;
            end else if (start) begin
                run       <= 1'b1;
                remaining <= req_count;
                req_err   <= 1'b0;
            end
            if (run && byte_strb) begin
                remaining <= remaining - 1'b1;
            end
            if (run && fall_tick && (remaining == '0)) begin
                run <= 1'b0;
            end
        end
    end

    rxs_clkgen #(.HALF(SCLK_HALF)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    rxs_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rise_tick (rise_tick),
        .miso      (miso),
        .byte_strb (byte_strb),
        .byte_out  (rx_byte)
    );

    rxs_packer u_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .byte_strb   (byte_strb),
        .byte_in     (rx_byte),
        .last_byte   (last_byte),
        .push_valid  (push_valid),
        .push_data   (word_q),
        .valid_bytes (vb_q)
    );

    // R1: an accepted request shows up as busy with the requested count.
    assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !busy && (req_count != '0)) |=> busy && (remaining == $past(req_count)));
    // R4: the remaining count never rises during a transfer.
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (remaining <= $past(remaining)));
    // R6: a short word can only be the final word of a transfer.
    assert_short_is_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && (valid_bytes != 3'd4)) |-> done);
    // R7: completion comes with a push and an exhausted count.
    assert_done_with_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> push_valid && (remaining == '0));
    // R8: a request during a transfer raises the error flag.
    assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && busy) |=> req_err);
    // R9: a zero-length request leaves the sequencer idle.
    assert_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !busy && (req_count == '0)) |=> !busy);
endmodule

// File: tb/rx_byte_seq_test.sv
module rx_byte_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_count = '0;
    logic        miso;
    logic        sclk, mosi, busy, req_err, push_valid, done;
    logic [15:0] remaining;
    logic [31:0] push_data;
    logic [2:0]  valid_bytes;

    int tests = 0;
    int fails = 0;
    int cur_n = 0;
    int bitidx = 0;
    int rises = 0;
    int pc = 0;
    int done_cnt = 0;
    logic mosi_bad = 1'b0;
    logic [31:0] pdata [0:15];
    logic [2:0]  pvb   [0:15];
    logic [15:0] prem  [0:15];
    logic        pdone [0:15];

    always #10 clk = ~clk;

    rx_byte_seq uut (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_count(req_count),
        .miso(miso), .sclk(sclk), .mosi(mosi), .busy(busy),
        .remaining(remaining), .req_err(req_err), .push_valid(push_valid),
        .push_data(push_data), .valid_bytes(valid_bytes), .done(done)
    );

    function automatic logic [7:0] tgt_byte(input int k, input int n);
        return 8'((k * 29) + (n * 7) + 60);
    endfunction

    assign miso = tgt_byte(bitidx / 8, cur_n)[7 - (bitidx % 8)];

    always @(negedge sclk) bitidx <= bitidx + 1;
    always @(posedge sclk) rises <= rises + 1;

    always @(negedge clk) begin
        if (rst_n && mosi !== 1'b1) mosi_bad <= 1'b1;
        if (rst_n && push_valid && pc < 16) begin
            pdata[pc] <= push_data;
            pvb[pc]   <= valid_bytes;
            prem[pc]  <= remaining;
            pdone[pc] <= done;
            pc <= pc + 1;
        end
        if (rst_n && done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic issue(input int n);
        @(negedge clk);
        req_wr = 1'b1;
        req_count = 16'(n);
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic clear_obs(input int n);
        cur_n = n; bitidx = 0; rises = 0; pc = 0; done_cnt = 0;
    endtask

    function automatic logic [31:0] exp_word(input int w, input int n);
        int first = 4 * w;
        int cnt = (n - first >= 4) ? 4 : n - first;
        logic [31:0] v = '0;
        for (int i = 0; i < cnt; i++) v = (v << 8) | 32'(tgt_byte(first + i, n));
        return v;
    endfunction

    task automatic run_len(input int n);
        int nw = (n + 3) / 4;
        clear_obs(n);
        issue(n);
        chk(busy === 1'b1, "R1 busy after start", 32'(busy), 1);
        chk(remaining === 16'(n), "R1 remaining loaded", 32'(remaining), 32'(n));
        wait_idle();
        chk(rises == 8 * n, "R2 sclk rising edges", 32'(rises), 32'(8 * n));
        chk(sclk === 1'b0, "R2 sclk parked low", 32'(sclk), 0);
        chk(pc == nw, "R5 push count", 32'(pc), 32'(nw));
        chk(done_cnt == 1, "R7 single done pulse", 32'(done_cnt), 1);
        chk(remaining === 16'd0, "R4 remaining at end", 32'(remaining), 0);
        for (int w = 0; w < nw && w < 16; w++) begin
            int vb = (n - 4 * w >= 4) ? 4 : n - 4 * w;
            int rem = n - 4 * w - vb;
            chk(pdata[w] === exp_word(w, n), (vb == 4) ? "R5 R3 full word data" : "R6 R3 short word data",
                pdata[w], exp_word(w, n));
            chk(pvb[w] === 3'(vb), (vb == 4) ? "R5 valid bytes" : "R6 valid bytes", 32'(pvb[w]), 32'(vb));
            chk(prem[w] === 16'(rem), "R4 remaining at push", 32'(prem[w]), 32'(rem));
            chk(pdone[w] === (w == nw - 1), "R7 done with final push", 32'(pdone[w]), 32'(w == nw - 1));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy === 1'b0 && sclk === 1'b0, "R10 busy/sclk after reset", {30'd0, busy, sclk}, 0);
        chk(remaining === 16'd0 && valid_bytes === 3'd0, "R10 counts after reset", {13'd0, valid_bytes, remaining}, 0);
        chk(push_valid === 1'b0 && done === 1'b0 && req_err === 1'b0, "R10 strobes after reset",
            {29'd0, push_valid, done, req_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int n = 1; n <= 13; n++) run_len(n);

        // R8: request while busy is ignored and flagged
        clear_obs(6);
        issue(6);
        repeat (40) @(negedge clk);
        issue(3);
        chk(req_err === 1'b1, "R8 error set on busy request", 32'(req_err), 1);
        chk(remaining < 16'd6 && remaining > 16'd0, "R8 remaining not reloaded", 32'(remaining), 32'(4));
        wait_idle();
        chk(rises == 48, "R8 edge count unchanged", 32'(rises), 48);
        chk(pc == 2 && pvb[1] === 3'd2, "R8 push shape unchanged", 32'(pc), 2);
        chk(pdata[1] === exp_word(1, 6), "R8 tail data", pdata[1], exp_word(1, 6));

        run_len(2);
        chk(req_err === 1'b0, "R8 error cleared by accepted request", 32'(req_err), 0);

        // R9: zero-length request
        clear_obs(0);
        issue(0);
        repeat (20) @(negedge clk);
        chk(busy === 1'b0, "R9 zero request stays idle", 32'(busy), 0);
        chk(rises == 0, "R9 no clock edges", 32'(rises), 0);
        chk(req_err === 1'b0, "R9 error unchanged", 32'(req_err), 0);

        chk(mosi_bad === 1'b0, "R2 mosi held idle", 32'(mosi_bad), 0);
        summary();
        $finish;
    end
endmodule